// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block decides which pending request the processor services next and gives the program-memory address the processor jumps to. It watches a reset request and a parameterized number of interrupt request lines. Each interrupt request is caught in a pending flag at a clock edge, so a one-cycle pulse is kept until it is serviced. A pending source is eligible when its own enable bit is one and the global interrupt enable is one. The reset request is always eligible. Among the eligible requests, the one with the lowest vector wins.

Every request owns a two-word slot in a vector table. Reset always sits at address zero. The interrupt slots start at zero or, when relocation is selected, at the boot-section base. Two boot-protection bits can block all interrupts while the program counter sits in one section and the vectors lie in the other. When the block takes a request it raises a take strobe and a one-hot acknowledge, clears the global enable and clears the pending flag of the source it served. A return-from-interrupt pulse turns the global enable back on.

Top module: `irq_vector_ctrl`

## Requirements
- R1: An interrupt source is taken only while its enable bit and the global enable are both one. A disabled source stays pending.
- R2: Reset uses vector index 0 at address 0. Interrupt source s (counting from 0) uses index s+1, and its address is the table base plus 2*(s+1). While nothing is taken, `ack` is all zero and `vec_addr` is 0.
- R3: When several eligible requests are present, the one with the lowest index wins.
- R4: A high `rst_req` is taken in every cycle it is high, whatever the enables, the protection bits or the program counter. It gives `ack[0]` and address 0, and it leaves interrupt pending flags untouched.
- R5: While `vec_reloc` is 1, the interrupt table base is BOOT_BASE. Otherwise the base is 0. The reset address stays 0.
- R6: While `prot_a` or `prot_b` is 1, all interrupts (not reset) are blocked in two cases: `pc` >= BOOT_BASE (boot section) with `vec_reloc`=0, and `pc` < BOOT_BASE with `vec_reloc`=1.
- R7: A take raises `take` and exactly one `ack` bit (bit index = vector index). At the following edge, `gie` reads 0 and the pending flag of the served source is cleared.
- R8: A `reti` pulse without a take sets `gie` to 1 at the next edge. A source that is still pending and enabled is then taken in that next cycle.
- R9: A one-cycle request pulse seen at an edge while `gie` is 0 is kept, and it is taken once `gie` becomes 1.
- R10: After `rst_n` is asserted, `gie` is 0, no source is pending, and `take` is 0.
- R11: `gie` is updated in priority order: a take clears it, otherwise `reti` sets it, otherwise `ie_wr` loads `ie_wdata`.

Interrupt source k in a bench check is request bit k, enable bit k, and `ack` bit k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NUM_IRQ | Interrupt request lines, latched each edge |
| irq_en | input | NUM_IRQ | Per-source enable mask |
| ie_wr | input | 1 | Load the global enable from `ie_wdata` |
| ie_wdata | input | 1 | Value written to the global enable |
| reti | input | 1 | Return-from-interrupt pulse, sets the global enable |
| vec_reloc | input | 1 | Place interrupt vectors at BOOT_BASE |
| pc | input | ADDR_W | Current program counter (word address) |
| prot_a | input | 1 | Boot-protection configuration bit A |
| prot_b | input | 1 | Boot-protection configuration bit B |
| rst_req | input | 1 | Reset request, highest priority |
| take | output | 1 | A request is taken this cycle |
| vec_addr | output | ADDR_W | Vector address of the taken request |
| ack | output | NUM_IRQ+1 | One-hot acknowledge, bit 0 = reset |
| gie | output | 1 | Current global interrupt enable |

## Verification
The hardest state to reach from the ports is a request that was caught while the global enable was low and is then released by a `reti` pulse, not by a plain write. The bench builds this state in steps. It first lets one interrupt be taken, which clears the enable. It then pulses a second source while the handler is notionally running and checks that nothing is taken. Only after that does it issue `reti` and look for the second vector in the very next cycle. The protection cases are reached by walking a vector table that places the program counter on both sides of the boot base, including the two addresses at the boundary.

// File: rtl/irq_vector_ctrl_pkg.sv
package irq_vector_ctrl_pkg;

  // Word address of a vector slot: table base plus two words per index.
  // Index 0 (reset) is never relocated.
  function automatic int unsigned ivc_vector(input int unsigned idx,
                                              input logic        reloc,
                                              input int unsigned boot_base);
    int unsigned base;
    base = (reloc && idx != 0) ? boot_base : 0;
    return base + 2 * idx;
  endfunction

  // Program counter lies in the boot section
  function automatic logic ivc_in_boot(input int unsigned pc_w,
                                       input int unsigned boot_base);
    return pc_w >= boot_base;
  endfunction

endpackage

// File: rtl/ivc_pending.sv
module ivc_pending #(
  parameter int NUM_IRQ = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] req,
  input  logic [NUM_IRQ-1:0] clr,
  output logic [NUM_IRQ-1:0] pend
);

  // A request arriving in the same cycle as its acknowledge is kept.
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pend[g] <= 1'b0;
      else
        pend[g] <= (pend[g] & ~clr[g]) | req[g];
    end
  end

endmodule

// File: rtl/ivc_gie.sv
module ivc_gie (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic reti,
  input  logic wr,
  input  logic wdata,
  output logic gie
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      gie <= 1'b0;
    else if (take)
      gie <= 1'b0;
    else if (reti)
      gie <= 1'b1;
    else if (wr)
      gie <= wdata;
  end

endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter #(
  parameter int N     = 7,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     cand,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  // Scan from the top down so the lowest set index is the last to write.
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) idx = IDX_W'(i);
    end
    any   = |cand;
    grant = any ? (N'(1) << idx) : '0;
  end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vector_ctrl_pkg::*;
#(
  parameter int NUM_IRQ   = 6,
  parameter int ADDR_W    = 14,
  parameter int BOOT_BASE = 14'h1C00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               ie_wr,
  input  logic               ie_wdata,
  input  logic               reti,
  input  logic               vec_reloc,
  input  logic [ADDR_W-1:0]  pc,
  input  logic               prot_a,
  input  logic               prot_b,
  input  logic               rst_req,
  output logic               take,
  output logic [ADDR_W-1:0]  vec_addr,
  output logic [NUM_IRQ:0]   ack,
  output logic               gie
);

  localparam int NSLOT = NUM_IRQ + 1;
  localparam int IDX_W = $clog2(NSLOT);

  // Named internal events, visible to the bound checker
  logic [NUM_IRQ-1:0] pend;
  logic               pc_boot;
  logic               prot_block;
  logic [NUM_IRQ-1:0] eligible;
  logic [NSLOT-1:0]   cand;
  logic [IDX_W-1:0]   win_idx;
  logic               win_any;

  ivc_pending #(.NUM_IRQ(NUM_IRQ)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (irq_req),
    .clr   (ack[NUM_IRQ:1]),
    .pend  (pend)
  );

  ivc_gie u_gie (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take),
    .reti  (reti),
    .wr    (ie_wr),
    .wdata (ie_wdata),
    .gie   (gie)
  );

  // Boot protection: block when the program counter and the table
  // sit in different sections.
  assign pc_boot    = ivc_in_boot(32'(pc), BOOT_BASE);
  assign prot_block = (prot_a | prot_b) & (pc_boot ^ vec_reloc);

  assign eligible = pend & irq_en & {NUM_IRQ{gie & ~prot_block}};
  assign cand     = {eligible, rst_req};

  ivc_arbiter #(.N(NSLOT), .IDX_W(IDX_W)) u_arb (
    .cand  (cand),
    .grant (ack),
    .idx   (win_idx),
    .any   (win_any)
  );

  assign take     = win_any;
  assign vec_addr = win_any
                  ? ADDR_W'(ivc_vector(32'(win_idx), vec_reloc, BOOT_BASE))
                  : '0;

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int NUM_IRQ   = 6,
  parameter int ADDR_W    = 14,
  parameter int BOOT_BASE = 14'h1C00
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_IRQ-1:0] irq_en,
  input logic               reti,
  input logic               vec_reloc,
  input logic [ADDR_W-1:0]  pc,
  input logic               prot_a,
  input logic               prot_b,
  input logic               rst_req,
  input logic               take,
  input logic [ADDR_W-1:0]  vec_addr,
  input logic [NUM_IRQ:0]   ack,
  input logic               gie
);

  logic crossed;
  assign crossed = (prot_a || prot_b) && ((pc >= ADDR_W'(BOOT_BASE)) != vec_reloc);

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack) && (take == (ack != '0))); // R7

  AST_GIE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !gie); // R7

  AST_RETI_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !take) |=> gie); // R8

  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !rst_req) |-> gie); // R1

  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (take && ack[0] && vec_addr == '0)); // R4

  AST_PROT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (crossed && !rst_req) |-> !take); // R6

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> (vec_addr == '0)); // R2

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_en
    AST_ACK_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      ack[k+1] |-> irq_en[k]); // R1
  end

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
  .NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .BOOT_BASE(BOOT_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .reti(reti),
  .vec_reloc(vec_reloc), .pc(pc), .prot_a(prot_a), .prot_b(prot_b),
  .rst_req(rst_req), .take(take), .vec_addr(vec_addr), .ack(ack), .gie(gie)
);

// File: tb/irq_vector_ctrl_test.sv
`timescale 1ns/1ps
module irq_vector_ctrl_test;

  localparam int N    = 6;
  localparam int AW   = 14;
  localparam int BOOT = 14'h1C00;
  // entry: {req, en, reloc, pc, prot{b,a}, exp_take, exp_src}
  localparam int EW   = N + N + 1 + AW + 2 + 1 + 3;
  localparam int NVEC = 11;

  localparam logic [EW-1:0] TBL [NVEC] = '{
    {6'b000001, 6'b111111, 1'b0, 14'h0100, 2'b00, 1'b1, 3'd0}, // R2 single source
    {6'b101000, 6'b111111, 1'b0, 14'h0100, 2'b00, 1'b1, 3'd3}, // R3 priority
    {6'b101000, 6'b110111, 1'b0, 14'h0100, 2'b00, 1'b1, 3'd5}, // R1 winner disabled
    {6'b000100, 6'b000000, 1'b0, 14'h0100, 2'b00, 1'b0, 3'd0}, // R1 none enabled
    {6'b010010, 6'b111111, 1'b1, 14'h0100, 2'b00, 1'b1, 3'd1}, // R5 relocated
    {6'b000001, 6'b111111, 1'b0, 14'h1D00, 2'b01, 1'b0, 3'd0}, // R6 boot pc, app table
    {6'b000001, 6'b111111, 1'b1, 14'h0100, 2'b10, 1'b0, 3'd0}, // R6 app pc, boot table
    {6'b100000, 6'b111111, 1'b1, 14'h1D00, 2'b01, 1'b1, 3'd5}, // R6 same section
    {6'b000100, 6'b111111, 1'b0, 14'h0200, 2'b11, 1'b1, 3'd2}, // R6 same section
    {6'b000001, 6'b111111, 1'b1, 14'h1BFF, 2'b01, 1'b0, 3'd0}, // R6 boundary below
    {6'b000001, 6'b111111, 1'b0, 14'h1C00, 2'b01, 1'b0, 3'd0}  // R6 boundary at base
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_req = '0;
  logic [N-1:0]  irq_en = '0;
  logic          ie_wr = 1'b0;
  logic          ie_wdata = 1'b0;
  logic          reti = 1'b0;
  logic          vec_reloc = 1'b0;
  logic [AW-1:0] pc = '0;
  logic          prot_a = 1'b0;
  logic          prot_b = 1'b0;
  logic          rst_req = 1'b0;
  logic          take;
  logic [AW-1:0] vec_addr;
  logic [N:0]    ack;
  logic          gie;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  irq_vector_ctrl #(.NUM_IRQ(N), .ADDR_W(AW), .BOOT_BASE(BOOT)) uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
    .ie_wr(ie_wr), .ie_wdata(ie_wdata), .reti(reti), .vec_reloc(vec_reloc),
    .pc(pc), .prot_a(prot_a), .prot_b(prot_b), .rst_req(rst_req),
    .take(take), .vec_addr(vec_addr), .ack(ack), .gie(gie)
  );

  // Expected address of interrupt source s: two words per slot, slot s+1.
  function automatic logic [AW-1:0] want_addr(input int s, input logic rel);
    return AW'((rel ? BOOT : 0) + 2 * (s + 1));
  endfunction

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    irq_req = '0; ie_wr = 1'b0; reti = 1'b0; rst_req = 1'b0;
    tick();
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R10 reset state
    do_reset();
    check("R10", "gie", gie, 0);
    check("R10", "take", take, 0);
    check("R10", "ack", ack, 0);
    irq_en = '1; ie_wr = 1'b1; ie_wdata = 1'b1;
    tick();
    ie_wr = 1'b0;
    check("R10", "no pending after reset", take, 0);

    // Table walk
    for (int e = 0; e < NVEC; e++) begin
      logic [EW-1:0] v;
      v = TBL[e];
      do_reset();
      irq_req   = v[EW-1 -: N];
      irq_en    = v[EW-N-1 -: N];
      vec_reloc = v[AW+6];
      pc        = v[AW+5 -: AW];
      prot_b    = v[5];
      prot_a    = v[4];
      ie_wr = 1'b1; ie_wdata = 1'b1;
      tick();
      irq_req = '0; ie_wr = 1'b0;
      check("R1/R3/R6", $sformatf("vec%0d take", e), take, v[3]);
      if (v[3]) begin
        check("R2/R5", $sformatf("vec%0d addr", e), vec_addr,
              want_addr(int'(v[2:0]), v[AW+6]));
        check("R7", $sformatf("vec%0d ack", e), ack, (N+1)'(1) << (v[2:0] + 1));
        tick();
        check("R7", $sformatf("vec%0d gie after take", e), gie, 0);
      end else begin
        check("R2", $sformatf("vec%0d idle addr", e), vec_addr, 0);
      end
    end

    // R9: pulse while gie is 0 is kept
    do_reset();
    vec_reloc = 1'b0; prot_a = 1'b0; prot_b = 1'b0; pc = 14'h0040;
    irq_en = '1;
    irq_req = 6'b010000;
    tick();
    irq_req = '0;
    tick(); tick();
    check("R9", "no take while gie 0", take, 0);
    ie_wr = 1'b1; ie_wdata = 1'b1;
    tick();
    ie_wr = 1'b0;
    check("R9", "latched pulse taken", take, 1);
    check("R9", "latched pulse addr", vec_addr, want_addr(4, 1'b0));
    tick();
    check("R7", "gie cleared", gie, 0);

    // R8: request during handler, released by reti
    irq_req = 6'b000100;
    tick();
    irq_req = '0;
    check("R8", "held during handler", take, 0);
    reti = 1'b1;
    tick();
    reti = 1'b0;
    check("R8", "gie restored", gie, 1);
    check("R8", "pending taken after reti", take, 1);
    check("R8", "addr after reti", vec_addr, want_addr(2, 1'b0));
    tick();

    // R7: served source is no longer pending
    ie_wr = 1'b1; ie_wdata = 1'b1;
    tick();
    ie_wr = 1'b0;
    check("R7", "pending cleared by ack", take, 0);

    // R11: take beats a simultaneous write of 1
    irq_req = 6'b000010;
    tick();
    irq_req = '0;
    ie_wr = 1'b1; ie_wdata = 1'b1;
    check("R11", "take present", take, 1);
    tick();
    ie_wr = 1'b0;
    check("R11", "take wins over write", gie, 0);

    // R4: reset request overrides a pending interrupt and all gating
    ie_wr = 1'b1; ie_wdata = 1'b1;
    irq_req = 6'b000001;
    tick();
    ie_wr = 1'b0; irq_req = '0;
    prot_a = 1'b1; pc = 14'h1E00; irq_en = '0;
    rst_req = 1'b1;
    #1;
    check("R4", "reset take", take, 1);
    check("R4", "reset ack", ack, 1);
    check("R4", "reset addr", vec_addr, 0);
    tick();
    rst_req = 1'b0; prot_a = 1'b0; pc = 14'h0040; irq_en = '1;
    ie_wr = 1'b1; ie_wdata = 1'b1;
    tick();
    ie_wr = 1'b0;
    check("R4", "interrupt still pending after reset take", take, 1);
    check("R4", "pending source addr", vec_addr, want_addr(0, 1'b0));
    tick();

    finish_run();
  end

endmodule